// File: doc/BRIEF.md
# SMBus Protocol Transaction Sequencer

This block runs one SMBus host transaction whenever the host asks for it. The host loads a protocol code, a target address byte, a command byte, two data bytes and, for block writes, a 32-entry block buffer. It then pulses `go_i`. The sequencer decodes the protocol code and the read flag and breaks the transfer into transaction-level bus operations: start, repeated start, byte write, byte read and stop. A bus engine outside the block performs each operation and reports back through a request/done handshake.

When the transfer ends, the results are written back into the same registers. Read bytes go to the two data registers or to the block buffer, and the status bits record success or device error. Bit timing, clock stretching, packet error checking and arbitration belong to the bus engine and are not handled here.

Status bit positions on `stat_o`: bit 0 busy, bit 1 interrupt, bit 2 device error, bit 3 byte done. Bus operation codes on `bus_op_o`: 0 start, 1 repeated start, 2 write byte, 3 read byte, 4 stop.

Top module: `smbseq_top`

## Requirements
- R1: After reset, `stat_o`, `data0_o` and `data1_o` are zero and `bus_req_o` is low.
- R2: `proto_i` selects the transfer. Code 0 is quick, 1 is send/receive byte, 2 is byte data, 3 is word data and 5 is block. Codes 4, 6 and 7 set device error (stat bit 2) without any bus operation.
- R3: Bit 0 of `addr_i` is the read flag and bits 7:1 are the target address. When a command byte is sent first, the first address byte goes out with bit 0 cleared. A read then follows with a repeated start and the address byte with bit 0 set.
- R4: A `go_i` pulse sets busy (bit 0), which clears one cycle later when execution begins. `go_i` is ignored while busy or while a transfer runs. If device error is already set, no bus operation occurs and device error stays set.
- R5: Quick sends only the address byte, with the read flag as given. Send byte writes the command byte after the address. Receive byte reads one byte into data0.
- R6: A byte-data write sends the command and then data0. A byte-data read stores the returned byte in data0.
- R7: A word write sends data0 and then data1. A word read stores the first byte in data0 and the second in data1. `bus_last_o` is high only on the final read byte of any transfer.
- R8: A block write sends the command, then the count byte taken from data0, then buffer entries 0 up to count-1. A count of 0 or above 32 gives device error with no bus operation.
- R9: A block read first reads a count byte, then that many bytes into buffer entries 0 upward, and sets data0 to the count. A count of 0 or above 32 ends the transfer with a stop and device error.
- R10: A transfer that succeeds sets byte done and interrupt after its stop completes. A slave NACK on any written byte leads to a stop and device error, and neither byte done nor interrupt is set.
- R11: `stat_clr_i` clears status bits write-one style: bit 0 clears interrupt, bit 1 device error and bit 2 byte done. No other bit is affected.
- R12: `bus_req_o`, `bus_op_o` and `bus_wdata_o` hold steady until `bus_done_i`, whatever the engine latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| go_i | input | 1 | Start request pulse |
| proto_i | input | 3 | Protocol code (control bits 4:2) |
| addr_i | input | 8 | Target address in bits 7:1, read flag in bit 0 |
| cmd_i | input | 8 | Command byte |
| dat_we_i | input | 2 | Host write enables for data0 (bit 0) and data1 (bit 1) |
| dat_wdata_i | input | 8 | Host write data for data registers |
| buf_we_i | input | 1 | Host block buffer write enable |
| buf_widx_i | input | 5 | Host block buffer write index |
| buf_wdata_i | input | 8 | Host block buffer write data |
| buf_ridx_i | input | 5 | Host block buffer read index |
| buf_rdata_o | output | 8 | Block buffer read data |
| stat_clr_i | input | 3 | Status clear mask |
| stat_o | output | 4 | Status bits |
| data0_o | output | 8 | Data register 0 |
| data1_o | output | 8 | Data register 1 |
| bus_req_o | output | 1 | Bus operation request |
| bus_op_o | output | 3 | Bus operation code |
| bus_wdata_o | output | 8 | Byte to write (address, command, data) |
| bus_last_o | output | 1 | Final read byte, master NACKs it |
| bus_done_i | input | 1 | Operation complete |
| bus_rdata_i | input | 8 | Byte read, valid with done |
| bus_nack_i | input | 1 | Slave NACK on a write, valid with done |

## Verification
The checks assume the bus engine raises `bus_done_i` only while a request is open and holds it for a single cycle per operation. They also assume the host changes the data registers and the buffer only between transfers. The bench's engine model answers each request after a programmable delay with a one-cycle done, and the host tasks load registers only after the previous status has appeared. Extra `go_i` pulses are issued mid-transfer on purpose, since the block must ignore them.

// File: rtl/smbseq_pkg.sv
package smbseq_pkg;
  typedef enum logic [2:0] {
    OP_START  = 3'd0,
    OP_RSTART = 3'd1,
    OP_WRITE  = 3'd2,
    OP_READ   = 3'd3,
    OP_STOP   = 3'd4
  } bus_op_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_START, ST_ADDR1, ST_CMD, ST_CNT, ST_WDAT,
    ST_RSTART, ST_ADDR2, ST_RCNT, ST_RDAT, ST_STOP
  } seq_st_e;

  localparam logic [2:0] P_QUICK = 3'd0;
  localparam logic [2:0] P_BYTE  = 3'd1;
  localparam logic [2:0] P_BDATA = 3'd2;
  localparam logic [2:0] P_WORD  = 3'd3;
  localparam logic [2:0] P_BLOCK = 3'd5;

  localparam int S_BUSY  = 0;
  localparam int S_INTR  = 1;
  localparam int S_DERR  = 2;
  localparam int S_BDONE = 3;
endpackage

// File: rtl/smbseq_blkbuf.sv
module smbseq_blkbuf #(
  parameter int DEPTH = 32,
  parameter int DW    = 8,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [IW-1:0] widx_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [IW-1:0] ridx_a_i,
  output logic [DW-1:0] rdata_a_o,
  input  logic [IW-1:0] ridx_b_i,
  output logic [DW-1:0] rdata_b_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[widx_i] <= wdata_i;
  end

  assign rdata_a_o = mem_q[ridx_a_i];
  assign rdata_b_o = mem_q[ridx_b_i];
endmodule

// File: rtl/smbseq_status.sv
module smbseq_status (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       go_acc_i,
  input  logic       launch_i,
  input  logic       fin_ok_i,
  input  logic       fin_err_i,
  input  logic [2:0] clr_i,
  output logic [3:0] stat_o
);
  logic busy_q, intr_q, derr_q, bdone_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      intr_q  <= 1'b0;
      derr_q  <= 1'b0;
      bdone_q <= 1'b0;
    end else begin
      if (go_acc_i)      busy_q <= 1'b1;
      else if (launch_i) busy_q <= 1'b0;
      if (fin_ok_i)      intr_q <= 1'b1;
      else if (clr_i[0]) intr_q <= 1'b0;
      if (fin_err_i)     derr_q <= 1'b1;
      else if (clr_i[1]) derr_q <= 1'b0;
      if (fin_ok_i)      bdone_q <= 1'b1;
      else if (clr_i[2]) bdone_q <= 1'b0;
    end
  end

  assign stat_o = {bdone_q, derr_q, intr_q, busy_q};
endmodule

// File: rtl/smbseq_ctrl.sv
module smbseq_ctrl
  import smbseq_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int IW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          busy_i,
  input  logic          dev_err_i,
  input  logic [2:0]    proto_i,
  input  logic [7:0]    addr_i,
  input  logic [7:0]    cmd_i,
  input  logic [7:0]    data0_i,
  input  logic [7:0]    data1_i,
  output logic          idle_o,
  output logic          launch_o,
  output logic          fin_ok_o,
  output logic          fin_err_o,
  output logic          d0_we_o,
  output logic          d1_we_o,
  output logic [7:0]    res_o,
  output logic          bw_we_o,
  output logic [IW-1:0] bw_idx_o,
  output logic [IW-1:0] br_idx_o,
  input  logic [7:0]    br_data_i,
  output logic          bus_req_o,
  output bus_op_e       bus_op_o,
  output logic [7:0]    bus_wdata_o,
  output logic          bus_last_o,
  input  logic          bus_done_i,
  input  logic [7:0]    bus_rdata_i,
  input  logic          bus_nack_i
);
  localparam logic [7:0] MAX_CNT = 8'(DEPTH);

  seq_st_e       st_q;
  logic [2:0]    prot_q;
  logic          rd_q;
  logic [6:0]    sa_q;
  logic [7:0]    cmd_q;
  logic [CW-1:0] idx_q, cnt_q;
  logic          err_q;

  logic proto_ok, blk_bad, pre_fail, has_cmd, cnt_ok, loop_end;
  logic [CW-1:0] idx_nxt;

  assign idle_o   = (st_q == ST_IDLE);
  assign launch_o = idle_o & busy_i;
  assign proto_ok = (proto_i <= P_WORD) | (proto_i == P_BLOCK);
  assign blk_bad  = (proto_i == P_BLOCK) & ~addr_i[0] &
                    ((data0_i == 8'd0) | (data0_i > MAX_CNT));
  assign pre_fail = launch_o & ~dev_err_i & (~proto_ok | blk_bad);
  assign has_cmd  = (prot_q != P_QUICK) & ~((prot_q == P_BYTE) & rd_q);
  assign cnt_ok   = (bus_rdata_i != 8'd0) & (bus_rdata_i <= MAX_CNT);
  assign idx_nxt  = idx_q + CW'(1);
  assign loop_end = (idx_nxt == cnt_q);

  assign fin_ok_o  = (st_q == ST_STOP) & bus_done_i & ~err_q;
  assign fin_err_o = pre_fail | ((st_q == ST_STOP) & bus_done_i & err_q);

  assign res_o    = bus_rdata_i;
  assign d0_we_o  = bus_done_i & (((st_q == ST_RDAT) & (prot_q != P_BLOCK) & (idx_q == '0)) |
                                  ((st_q == ST_RCNT) & cnt_ok));
  assign d1_we_o  = bus_done_i & (st_q == ST_RDAT) & (prot_q == P_WORD) & (idx_q == CW'(1));
  assign bw_we_o  = bus_done_i & (st_q == ST_RDAT) & (prot_q == P_BLOCK);
  assign bw_idx_o = idx_q[IW-1:0];
  assign br_idx_o = idx_q[IW-1:0];

  assign bus_req_o  = ~idle_o;
  assign bus_last_o = (st_q == ST_RDAT) & loop_end;

  always_comb begin
    bus_op_o    = OP_WRITE;
    bus_wdata_o = 8'd0;
    unique case (st_q)
      ST_START:  bus_op_o = OP_START;
      ST_RSTART: bus_op_o = OP_RSTART;
      ST_STOP:   bus_op_o = OP_STOP;
      ST_RCNT, ST_RDAT: bus_op_o = OP_READ;
      ST_ADDR1:  bus_wdata_o = {sa_q, has_cmd ? 1'b0 : rd_q};
      ST_ADDR2:  bus_wdata_o = {sa_q, 1'b1};
      ST_CMD:    bus_wdata_o = cmd_q;
      ST_CNT:    bus_wdata_o = 8'(cnt_q);
      ST_WDAT:   bus_wdata_o = (prot_q == P_BLOCK) ? br_data_i :
                               (idx_q == '0) ? data0_i : data1_i;
      default:   bus_op_o = OP_WRITE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      prot_q <= P_QUICK;
      rd_q   <= 1'b0;
      sa_q   <= '0;
      cmd_q  <= '0;
      idx_q  <= '0;
      cnt_q  <= '0;
      err_q  <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (launch_o && !dev_err_i && !pre_fail) begin
          prot_q <= proto_i;
          rd_q   <= addr_i[0];
          sa_q   <= addr_i[7:1];
          cmd_q  <= cmd_i;
          cnt_q  <= CW'(data0_i);
          idx_q  <= '0;
          err_q  <= 1'b0;
          st_q   <= ST_START;
        end
        ST_START:  if (bus_done_i) st_q <= ST_ADDR1;
        ST_RSTART: if (bus_done_i) st_q <= ST_ADDR2;
        ST_ADDR1: if (bus_done_i) begin
          if (bus_nack_i) begin
            err_q <= 1'b1;
            st_q  <= ST_STOP;
          end else if (prot_q == P_QUICK) begin
            st_q <= ST_STOP;
          end else if (!has_cmd) begin
            cnt_q <= CW'(1);
            idx_q <= '0;
            st_q  <= ST_RDAT;
          end else begin
            st_q <= ST_CMD;
          end
        end
        ST_CMD: if (bus_done_i) begin
          idx_q <= '0;
          if (bus_nack_i) begin
            err_q <= 1'b1;
            st_q  <= ST_STOP;
          end else if (prot_q == P_BYTE) begin
            st_q <= ST_STOP;
          end else if (rd_q) begin
            st_q <= ST_RSTART;
          end else if (prot_q == P_BLOCK) begin
            st_q <= ST_CNT;
          end else begin
            cnt_q <= (prot_q == P_WORD) ? CW'(2) : CW'(1);
            st_q  <= ST_WDAT;
          end
        end
        ST_CNT: if (bus_done_i) begin
          if (bus_nack_i) begin
            err_q <= 1'b1;
            st_q  <= ST_STOP;
          end else begin
            st_q <= ST_WDAT;
          end
        end
        ST_WDAT: if (bus_done_i) begin
          idx_q <= idx_nxt;
          if (bus_nack_i) begin
            err_q <= 1'b1;
            st_q  <= ST_STOP;
          end else if (loop_end) begin
            st_q <= ST_STOP;
          end
        end
        ST_ADDR2: if (bus_done_i) begin
          idx_q <= '0;
          if (bus_nack_i) begin
            err_q <= 1'b1;
            st_q  <= ST_STOP;
          end else if (prot_q == P_BLOCK) begin
            st_q <= ST_RCNT;
          end else begin
            cnt_q <= (prot_q == P_WORD) ? CW'(2) : CW'(1);
            st_q  <= ST_RDAT;
          end
        end
        ST_RCNT: if (bus_done_i) begin
          if (cnt_ok) begin
            cnt_q <= CW'(bus_rdata_i);
            idx_q <= '0;
            st_q  <= ST_RDAT;
          end else begin
            err_q <= 1'b1;
            st_q  <= ST_STOP;
          end
        end
        ST_RDAT: if (bus_done_i) begin
          idx_q <= idx_nxt;
          if (loop_end) st_q <= ST_STOP;
        end
        ST_STOP: if (bus_done_i) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/smbseq_top.sv
module smbseq_top
  import smbseq_pkg::*;
#(
  parameter int BUF_DEPTH = 32,
  localparam int IW       = $clog2(BUF_DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          go_i,
  input  logic [2:0]    proto_i,
  input  logic [7:0]    addr_i,
  input  logic [7:0]    cmd_i,
  input  logic [1:0]    dat_we_i,
  input  logic [7:0]    dat_wdata_i,
  input  logic          buf_we_i,
  input  logic [IW-1:0] buf_widx_i,
  input  logic [7:0]    buf_wdata_i,
  input  logic [IW-1:0] buf_ridx_i,
  output logic [7:0]    buf_rdata_o,
  input  logic [2:0]    stat_clr_i,
  output logic [3:0]    stat_o,
  output logic [7:0]    data0_o,
  output logic [7:0]    data1_o,
  output logic          bus_req_o,
  output logic [2:0]    bus_op_o,
  output logic [7:0]    bus_wdata_o,
  output logic          bus_last_o,
  input  logic          bus_done_i,
  input  logic [7:0]    bus_rdata_i,
  input  logic          bus_nack_i
);
  logic          idle, launch, fin_ok, fin_err, go_acc;
  logic          d0_we, d1_we, bw_we;
  logic [7:0]    res, br_data;
  logic [IW-1:0] bw_idx, br_idx;
  logic [7:0]    data0_q, data1_q;
  bus_op_e       op;

  assign go_acc = go_i & idle & ~stat_o[S_BUSY];

  smbseq_status u_status (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .go_acc_i  (go_acc),
    .launch_i  (launch),
    .fin_ok_i  (fin_ok),
    .fin_err_i (fin_err),
    .clr_i     (stat_clr_i),
    .stat_o    (stat_o)
  );

  smbseq_ctrl #(.DEPTH(BUF_DEPTH)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .busy_i      (stat_o[S_BUSY]),
    .dev_err_i   (stat_o[S_DERR]),
    .proto_i     (proto_i),
    .addr_i      (addr_i),
    .cmd_i       (cmd_i),
    .data0_i     (data0_q),
    .data1_i     (data1_q),
    .idle_o      (idle),
    .launch_o    (launch),
    .fin_ok_o    (fin_ok),
    .fin_err_o   (fin_err),
    .d0_we_o     (d0_we),
    .d1_we_o     (d1_we),
    .res_o       (res),
    .bw_we_o     (bw_we),
    .bw_idx_o    (bw_idx),
    .br_idx_o    (br_idx),
    .br_data_i   (br_data),
    .bus_req_o   (bus_req_o),
    .bus_op_o    (op),
    .bus_wdata_o (bus_wdata_o),
    .bus_last_o  (bus_last_o),
    .bus_done_i  (bus_done_i),
    .bus_rdata_i (bus_rdata_i),
    .bus_nack_i  (bus_nack_i)
  );

  assign bus_op_o = op;

  // sequencer write-back takes precedence over host loads
  smbseq_blkbuf #(.DEPTH(BUF_DEPTH), .DW(8)) u_buf (
    .clk_i     (clk_i),
    .we_i      (bw_we | buf_we_i),
    .widx_i    (bw_we ? bw_idx : buf_widx_i),
    .wdata_i   (bw_we ? res : buf_wdata_i),
    .ridx_a_i  (buf_ridx_i),
    .rdata_a_o (buf_rdata_o),
    .ridx_b_i  (br_idx),
    .rdata_b_o (br_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data0_q <= '0;
      data1_q <= '0;
    end else begin
      if (d0_we)            data0_q <= res;
      else if (dat_we_i[0]) data0_q <= dat_wdata_i;
      if (d1_we)            data1_q <= res;
      else if (dat_we_i[1]) data1_q <= dat_wdata_i;
    end
  end

  assign data0_o = data0_q;
  assign data1_o = data1_q;
endmodule

// File: rtl/smbseq_chk.sv
module smbseq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [3:0] stat_o,
  input logic       bus_req_o,
  input logic [2:0] bus_op_o,
  input logic [7:0] bus_wdata_o,
  input logic       bus_done_i
);
  assert_req_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_done_i |=> bus_req_o && $stable(bus_op_o) && $stable(bus_wdata_o));

  assert_busy_brief_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_o[0] |=> !stat_o[0]);

  assert_blocked_no_bus_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_o[0] && stat_o[2] |=> !bus_req_o);

  assert_ok_pair_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stat_o[3]) |-> stat_o[1] && !$rose(stat_o[2]));

  assert_intr_after_stop_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stat_o[1]) |-> $past(bus_req_o && bus_op_o == 3'd4 && bus_done_i));

  assert_idle_on_bad_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stat_o[2]) && !$past(bus_req_o) |-> !bus_req_o);
endmodule

bind smbseq_top smbseq_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .stat_o      (stat_o),
  .bus_req_o   (bus_req_o),
  .bus_op_o    (bus_op_o),
  .bus_wdata_o (bus_wdata_o),
  .bus_done_i  (bus_done_i)
);

// File: tb/smbseq_top_tb.sv
`timescale 1ns/1ps
module smbseq_top_tb;
  localparam int CYC = 10;

  logic       clk_i = 0, rst_ni = 0, go_i = 0;
  logic [2:0] proto_i = 0;
  logic [7:0] addr_i = 0, cmd_i = 0;
  logic [1:0] dat_we_i = 0;
  logic [7:0] dat_wdata_i = 0;
  logic       buf_we_i = 0;
  logic [4:0] buf_widx_i = 0, buf_ridx_i = 0;
  logic [7:0] buf_wdata_i = 0, buf_rdata_o;
  logic [2:0] stat_clr_i = 0;
  logic [3:0] stat_o;
  logic [7:0] data0_o, data1_o;
  logic       bus_req_o, bus_last_o;
  logic [2:0] bus_op_o;
  logic [7:0] bus_wdata_o;
  logic       bus_done_i = 0, bus_nack_i = 0;
  logic [7:0] bus_rdata_i = 0;

  int total = 0, bad = 0;
  bit fin = 0;

  smbseq_top u_dut (.*);

  always #(CYC/2) clk_i = ~clk_i;

  // bus engine model
  logic [11:0] log_w [64];
  logic [11:0] exp_w [64];
  logic [7:0]  rsp [64];
  int log_n = 0, exp_n = 0, rsp_p = 0, nack_at = -1, bus_lat = 0, wait_c = 0;

  always @(negedge clk_i) begin
    if (bus_req_o && !bus_done_i) begin
      if (wait_c < bus_lat) begin
        wait_c++;
      end else begin
        wait_c = 0;
        bus_nack_i = (log_n == nack_at);
        if (bus_op_o == 3'd3) begin
          bus_rdata_i = rsp[rsp_p];
          rsp_p++;
          log_w[log_n] = {bus_last_o, bus_op_o, bus_rdata_i};
        end else begin
          bus_rdata_i = 8'h00;
          log_w[log_n] = {bus_last_o, bus_op_o, bus_wdata_o};
        end
        if (log_n < 63) log_n++;
        bus_done_i = 1;
      end
    end else begin
      bus_done_i = 0;
      bus_nack_i = 0;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic clr_all();
    exp_n = 0; log_n = 0; rsp_p = 0; nack_at = -1;
  endtask

  task automatic ex(input logic [2:0] op, input logic [7:0] d, input logic last);
    exp_w[exp_n] = {last, op, d};
    exp_n++;
  endtask

  task automatic cmp_log(input string req);
    bit ok = (log_n == exp_n);
    int at = -1;
    for (int i = 0; i < exp_n && i < log_n; i++)
      if (ok && log_w[i] != exp_w[i]) begin ok = 0; at = i; end
    if (at >= 0) chk(0, req, $sformatf("bus op %0d", at), int'(log_w[at]), int'(exp_w[at]));
    else         chk(ok, req, "bus op count", log_n, exp_n);
  endtask

  task automatic set_dat(input logic [7:0] d0, input logic [7:0] d1);
    @(negedge clk_i);
    dat_we_i = 2'b11; dat_wdata_i = d0;
    @(negedge clk_i);
    dat_we_i = 2'b10; dat_wdata_i = d1;
    @(negedge clk_i);
    dat_we_i = 2'b00;
  endtask

  task automatic set_buf(input int i, input logic [7:0] d);
    @(negedge clk_i);
    buf_we_i = 1; buf_widx_i = 5'(i); buf_wdata_i = d;
    @(negedge clk_i);
    buf_we_i = 0;
  endtask

  task automatic clr_stat();
    @(negedge clk_i);
    stat_clr_i = 3'b111;
    @(negedge clk_i);
    stat_clr_i = 3'b000;
  endtask

  logic busy_seen, busy_after;

  task automatic run(input logic [2:0] p, input logic [7:0] a, input logic [7:0] c);
    @(negedge clk_i);
    proto_i = p; addr_i = a; cmd_i = c; go_i = 1;
    @(negedge clk_i);
    go_i = 0;
    busy_seen = stat_o[0];
    @(negedge clk_i);
    busy_after = stat_o[0];
    for (int i = 0; i < 500 && !(stat_o[1] | stat_o[2]); i++) @(negedge clk_i);
    repeat (2) @(negedge clk_i);
  endtask

  task automatic t_reset();
    chk(stat_o == 4'h0, "R1", "status", stat_o, 0);
    chk(data0_o == 8'h0 && data1_o == 8'h0, "R1", "data regs", {data1_o, data0_o}, 0);
    chk(!bus_req_o, "R1", "bus request", bus_req_o, 0);
  endtask

  task automatic t_quick();
    clr_stat(); clr_all();
    ex(3'd0, 8'h00, 0); ex(3'd2, 8'h51, 0); ex(3'd4, 8'h00, 0);
    run(3'd0, 8'h51, 8'hEE);
    chk(busy_seen == 1'b1, "R4", "busy after go", busy_seen, 1);
    chk(busy_after == 1'b0, "R4", "busy cleared at launch", busy_after, 0);
    cmp_log("R5");
    chk(stat_o == 4'b1010, "R10", "quick status", stat_o, 4'b1010);
  endtask

  task automatic t_send();
    clr_stat(); clr_all();
    ex(3'd0, 8'h00, 0); ex(3'd2, 8'hA0, 0); ex(3'd2, 8'h3C, 0); ex(3'd4, 8'h00, 0);
    run(3'd1, 8'hA0, 8'h3C);
    cmp_log("R5");
  endtask

  task automatic t_recv();
    clr_stat(); clr_all();
    rsp[0] = 8'h77;
    ex(3'd0, 8'h00, 0); ex(3'd2, 8'hA1, 0); ex(3'd3, 8'h77, 1); ex(3'd4, 8'h00, 0);
    run(3'd1, 8'hA1, 8'h00);
    cmp_log("R5");
    chk(data0_o == 8'h77, "R5", "receive data0", data0_o, 8'h77);
  endtask

  task automatic t_bytew();
    clr_stat(); set_dat(8'h5A, 8'h00); clr_all();
    ex(3'd0, 8'h00, 0); ex(3'd2, 8'hA0, 0); ex(3'd2, 8'h10, 0); ex(3'd2, 8'h5A, 0); ex(3'd4, 8'h00, 0);
    run(3'd2, 8'hA0, 8'h10);
    cmp_log("R6");
  endtask

  task automatic t_byter();
    clr_stat(); clr_all();
    rsp[0] = 8'h99;
    ex(3'd0, 8'h00, 0); ex(3'd2, 8'hA0, 0); ex(3'd2, 8'h11, 0);
    ex(3'd1, 8'h00, 0); ex(3'd2, 8'hA1, 0); ex(3'd3, 8'h99, 1); ex(3'd4, 8'h00, 0);
    run(3'd2, 8'hA1, 8'h11);
    cmp_log("R3");
    chk(data0_o == 8'h99, "R6", "byte read data0", data0_o, 8'h99);
    chk(stat_o == 4'b1010, "R10", "byte read status", stat_o, 4'b1010);
  endtask

  task automatic t_wordw(input int lat, input string req);
    clr_stat(); set_dat(8'h34, 8'h12); clr_all();
    bus_lat = lat;
    ex(3'd0, 8'h00, 0); ex(3'd2, 8'hB0, 0); ex(3'd2, 8'h20, 0);
    ex(3'd2, 8'h34, 0); ex(3'd2, 8'h12, 0); ex(3'd4, 8'h00, 0);
    fork
      run(3'd3, 8'hB0, 8'h20);
      begin
        repeat (6) @(negedge clk_i);
        go_i = 1;
        @(negedge clk_i);
        go_i = 0;
      end
    join
    repeat (8) @(negedge clk_i);
    cmp_log(req);
    chk(stat_o == 4'b1010, req, "word write status", stat_o, 4'b1010);
    bus_lat = 0;
  endtask

  task automatic t_wordr();
    clr_stat(); clr_all();
    rsp[0] = 8'hCD; rsp[1] = 8'hAB;
    ex(3'd0, 8'h00, 0); ex(3'd2, 8'hB0, 0); ex(3'd2, 8'h21, 0); ex(3'd1, 8'h00, 0);
    ex(3'd2, 8'hB1, 0); ex(3'd3, 8'hCD, 0); ex(3'd3, 8'hAB, 1); ex(3'd4, 8'h00, 0);
    run(3'd3, 8'hB1, 8'h21);
    cmp_log("R7");
    chk(data0_o == 8'hCD && data1_o == 8'hAB, "R7", "word read regs", {data1_o, data0_o}, 16'hABCD);
  endtask

  task automatic t_blkw();
    clr_stat();
    set_buf(0, 8'hE1); set_buf(1, 8'hE2); set_buf(2, 8'hE3);
    set_dat(8'd3, 8'h00); clr_all();
    ex(3'd0, 8'h00, 0); ex(3'd2, 8'hC0, 0); ex(3'd2, 8'h40, 0); ex(3'd2, 8'h03, 0);
    ex(3'd2, 8'hE1, 0); ex(3'd2, 8'hE2, 0); ex(3'd2, 8'hE3, 0); ex(3'd4, 8'h00, 0);
    run(3'd5, 8'hC0, 8'h40);
    cmp_log("R8");
    chk(stat_o == 4'b1010, "R8", "block write status", stat_o, 4'b1010);
  endtask

  task automatic t_blkw_bad(input logic [7:0] n);
    clr_stat(); set_dat(n, 8'h00); clr_all();
    run(3'd5, 8'hC0, 8'h40);
    chk(log_n == 0, "R8", "bad count bus ops", log_n, 0);
    chk(stat_o == 4'b0100, "R8", "bad count status", stat_o, 4'b0100);
  endtask

  task automatic t_blkr();
    clr_stat(); clr_all();
    rsp[0] = 8'd4; rsp[1] = 8'h10; rsp[2] = 8'h11; rsp[3] = 8'h12; rsp[4] = 8'h13;
    ex(3'd0, 8'h00, 0); ex(3'd2, 8'hC0, 0); ex(3'd2, 8'h41, 0); ex(3'd1, 8'h00, 0);
    ex(3'd2, 8'hC1, 0); ex(3'd3, 8'h04, 0); ex(3'd3, 8'h10, 0); ex(3'd3, 8'h11, 0);
    ex(3'd3, 8'h12, 0); ex(3'd3, 8'h13, 1); ex(3'd4, 8'h00, 0);
    run(3'd5, 8'hC1, 8'h41);
    cmp_log("R9");
    chk(data0_o == 8'd4, "R9", "block read count", data0_o, 4);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_i);
      buf_ridx_i = 5'(i);
      #1;
      chk(buf_rdata_o == 8'(8'h10 + i), "R9", "block read buffer", buf_rdata_o, 8'h10 + i);
    end
  endtask

  task automatic t_blkr_bad();
    clr_stat(); clr_all();
    rsp[0] = 8'd40;
    ex(3'd0, 8'h00, 0); ex(3'd2, 8'hC0, 0); ex(3'd2, 8'h42, 0); ex(3'd1, 8'h00, 0);
    ex(3'd2, 8'hC1, 0); ex(3'd3, 8'd40, 0); ex(3'd4, 8'h00, 0);
    run(3'd5, 8'hC1, 8'h42);
    cmp_log("R9");
    chk(stat_o == 4'b0100, "R9", "bad read count status", stat_o, 4'b0100);
  endtask

  task automatic t_nack();
    clr_stat(); set_dat(8'h5A, 8'h00); clr_all();
    nack_at = 2;
    ex(3'd0, 8'h00, 0); ex(3'd2, 8'hA0, 0); ex(3'd2, 8'h10, 0); ex(3'd4, 8'h00, 0);
    run(3'd2, 8'hA0, 8'h10);
    cmp_log("R10");
    chk(stat_o == 4'b0100, "R10", "nack status", stat_o, 4'b0100);
  endtask

  task automatic t_badprot(input logic [2:0] p);
    clr_stat(); clr_all();
    run(p, 8'hA0, 8'h10);
    chk(log_n == 0, "R2", "invalid code bus ops", log_n, 0);
    chk(stat_o == 4'b0100, "R2", "invalid code status", stat_o, 4'b0100);
  endtask

  task automatic t_preerr();
    clr_all();
    run(3'd0, 8'h50, 8'h00);
    repeat (4) @(negedge clk_i);
    chk(log_n == 0, "R4", "blocked bus ops", log_n, 0);
    chk(stat_o == 4'b0100, "R4", "blocked status", stat_o, 4'b0100);
  endtask

  task automatic t_clr();
    clr_stat(); clr_all();
    run(3'd0, 8'h50, 8'h00);
    @(negedge clk_i);
    stat_clr_i = 3'b001;
    @(negedge clk_i);
    stat_clr_i = 3'b000;
    chk(stat_o == 4'b1000, "R11", "clear intr only", stat_o, 4'b1000);
    stat_clr_i = 3'b100;
    @(negedge clk_i);
    stat_clr_i = 3'b000;
    chk(stat_o == 4'b0000, "R11", "clear byte done", stat_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    t_reset();
    t_quick();
    t_send();
    t_recv();
    t_bytew();
    t_byter();
    t_wordw(0, "R7");
    t_wordr();
    t_blkw();
    t_blkw_bad(8'd0);
    t_blkw_bad(8'd33);
    t_blkr();
    t_blkr_bad();
    t_nack();
    t_badprot(3'd4);
    t_badprot(3'd7);
    t_preerr();
    t_clr();
    t_wordw(3, "R12");
    fin = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CYC * 100000);
    if (!fin) begin
      total++;
      bad++;
      $display("FAIL R12 watchdog: actual=hung expected=complete");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule